// File: doc/BRIEF.md
# Masked-Pattern Trace Sample Monitor

This block watches a 64-bit data set that a host unit presents with a valid strobe. While the monitor is switched on, every valid sample goes to two independent masked comparators. A hit on the first comparator raises a timestamp request, which a separate enable bit must allow. A hit on the second comparator pulses a trigger line. Alongside the comparators, a collection gate passes samples on for tracing. In the all-samples mode it passes every valid sample. In the change-only mode it passes a sample only when the value differs from the sample accepted before it.

Software sets the block up through a plain 32-bit register port with read and write strobes and a word address. Each 64-bit pattern and each 64-bit mask takes two consecutive register words, with the lower word holding the low half. A mask bit of 1 makes the matching data bit take part in the compare. A mask bit of 0 excludes that data bit. The sample-side outputs are registered and appear one cycle after the sample is taken.

Top module: `trc_pattern_monitor`

## Requirements
- R1: After reset, all configuration registers hold zero, and `fwd_valid`, `ts_req`, `trig_out` and `reg_rdata` are all zero.
- R2: Register words, given as word addresses (byte offset / 4), are as follows. 0x280 is control, with bit 0 = monitor on and bit 1 = collection mode (0 all samples, 1 change-only). 0x281 is the timestamp enable, bit 0. The remaining bits of these two words read as zero. A read strobe returns the selected word on `reg_rdata` in the next cycle, and `reg_rdata` holds its value until the next read. A write takes effect from the next cycle.
- R3: Reads of any word address other than 0x280–0x289 return zero, and writes to those addresses change nothing.
- R4: A sample matches a pattern when every bit whose mask bit is 1 equals the pattern bit. Bits with a mask bit of 0 are ignored, so an all-zero mask matches every sample.
- R5: One cycle after each accepted sample that matches the trigger pattern (words 0x286/0x287, mask 0x288/0x289), `trig_out` is high for one cycle. Otherwise it is low.
- R6: One cycle after each accepted sample that matches the timestamp pattern (words 0x282/0x283, mask 0x284/0x285), `ts_req` is high for one cycle, but only while the timestamp enable bit is set. Otherwise it is low.
- R7: A sample is accepted only when `smp_valid` is high and the monitor-on bit is set. While that bit is clear, no output pulses and samples leave no state behind.
- R8: In all-samples mode, every accepted sample appears on `fwd_data`, with `fwd_valid` high, exactly one cycle later.
- R9: In change-only mode, an accepted sample is forwarded one cycle later only if it differs from the previous accepted sample. The first accepted sample after the monitor is switched on is always forwarded.
- R10: For each 64-bit pattern and mask, the word at the lower address holds bits 31:0 and the word at the higher address holds bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| smp_valid | input | 1 | Sample valid strobe |
| smp_data | input | 64 | Monitored data set |
| fwd_valid | output | 1 | Forwarded sample strobe |
| fwd_data | output | 64 | Forwarded sample value |
| ts_req | output | 1 | Timestamp request pulse |
| trig_out | output | 1 | Trigger pulse |

## Verification
Each comparator is tried with three kinds of input. Samples that match under full masks show the compare itself working. A sample with its two 32-bit halves swapped shows that the words are ordered correctly. A zero mask, and then a partial mask, show whether ignored bits really drop out of the compare. The timestamp path runs with its enable bit cleared and then set, on the same hitting samples, so the enable gating is isolated. The collection gate gets runs of repeated values, alternating values, and an off/on toggle between two identical samples. This separates forwarding on change from forwarding of the first sample after switch-on. A long random stretch then mixes register writes and reads with sparse samples from a small value set, comparing every output on every clock.

// File: rtl/trc_mon_pkg.sv
package trc_mon_pkg;
   typedef enum logic {
      COLLECT_ALL    = 1'b0,
      COLLECT_CHANGE = 1'b1
   } collect_mode_e;

   localparam int CTRL_ON_BIT   = 0;
   localparam int CTRL_MODE_BIT = 1;
   localparam int TSEN_BIT      = 0;
   // pattern regions in address order after the two control words
   localparam int REGION_TS_PAT  = 0;
   localparam int REGION_TS_MASK = 1;
   localparam int REGION_TR_PAT  = 2;
   localparam int REGION_TR_MASK = 3;
   localparam int NUM_REGIONS    = 4;
endpackage

// File: rtl/trc_mon_regs.sv
module trc_mon_regs
   import trc_mon_pkg::*;
#(
   parameter int          REG_W     = 32,
   parameter int          ADDR_W    = 10,
   parameter int          NW        = 2,
   parameter int unsigned BASE_WORD = 'h280
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [REG_W-1:0]     wdata,
   output logic [REG_W-1:0]     rdata,
   output logic                 mon_on,
   output collect_mode_e        mode,
   output logic                 ts_en,
   output logic [NW*REG_W-1:0]  ts_pat,
   output logic [NW*REG_W-1:0]  ts_mask,
   output logic [NW*REG_W-1:0]  tr_pat,
   output logic [NW*REG_W-1:0]  tr_mask
);
   localparam int              NREG   = 2 + NUM_REGIONS * NW;
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_WORD);

   if (BASE_WORD + NREG > 2 ** ADDR_W) begin : g_bad_map
      $error("register window does not fit the address width");
   end
   if (REG_W < 2) begin : g_bad_w
      $error("register width too small for control bits");
   end

   logic [ADDR_W-1:0] off;
   logic              in_map;
   logic [REG_W-1:0]  pat_q [NUM_REGIONS][NW];
   logic [REG_W-1:0]  rd_val;

   assign off    = addr - BASE_A;
   assign in_map = (addr >= BASE_A) && (off < ADDR_W'(NREG));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mon_on <= 1'b0;
         mode   <= COLLECT_ALL;
         ts_en  <= 1'b0;
      end else if (wr_en && in_map) begin
         if (off == ADDR_W'(0)) begin
            mon_on <= wdata[CTRL_ON_BIT];
            mode   <= collect_mode_e'(wdata[CTRL_MODE_BIT]);
         end
         if (off == ADDR_W'(1)) ts_en <= wdata[TSEN_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NUM_REGIONS; r++)
            for (int w = 0; w < NW; w++)
               pat_q[r][w] <= '0;
      end else if (wr_en && in_map) begin
         for (int r = 0; r < NUM_REGIONS; r++)
            for (int w = 0; w < NW; w++)
               if (off == ADDR_W'(2 + r * NW + w)) pat_q[r][w] <= wdata;
      end
   end

   for (genvar w = 0; w < NW; w++) begin : g_flat
      assign ts_pat [w*REG_W +: REG_W] = pat_q[REGION_TS_PAT][w];
      assign ts_mask[w*REG_W +: REG_W] = pat_q[REGION_TS_MASK][w];
      assign tr_pat [w*REG_W +: REG_W] = pat_q[REGION_TR_PAT][w];
      assign tr_mask[w*REG_W +: REG_W] = pat_q[REGION_TR_MASK][w];
   end

   always_comb begin
      rd_val = '0;
      if (in_map) begin
         if (off == ADDR_W'(0)) begin
            rd_val[CTRL_ON_BIT]   = mon_on;
            rd_val[CTRL_MODE_BIT] = mode;
         end
         if (off == ADDR_W'(1)) rd_val[TSEN_BIT] = ts_en;
         for (int r = 0; r < NUM_REGIONS; r++)
            for (int w = 0; w < NW; w++)
               if (off == ADDR_W'(2 + r * NW + w)) rd_val = pat_q[r][w];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
   end

   assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !in_map) |=> (rdata == '0));
   assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

// File: rtl/trc_mon_match.sv
module trc_mon_match #(
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          gate,
   input  logic [DW-1:0] data,
   input  logic [DW-1:0] pat,
   input  logic [DW-1:0] mask,
   output logic          hit_q
);
   if (DW < 1) begin : g_bad_dw
      $error("data width must be positive");
   end

   logic [DW-1:0] diff;
   assign diff = (data ^ pat) & mask;

   always_ff @(posedge clk) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= accept && gate && (diff == '0);
   end

   assert_zero_mask_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && gate && mask == '0) |=> hit_q);
   assert_hit_needs_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |-> $past(accept && gate));
endmodule

// File: rtl/trc_mon_collect.sv
module trc_mon_collect
   import trc_mon_pkg::*;
#(
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mon_on,
   input  collect_mode_e mode,
   input  logic          valid,
   input  logic [DW-1:0] data,
   output logic          fwd_valid,
   output logic [DW-1:0] fwd_data
);
   logic          have_q;
   logic [DW-1:0] prev_q;
   logic          take;
   logic          pass;

   assign take = mon_on && valid;
   assign pass = take && ((mode == COLLECT_ALL) || !have_q || (data != prev_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_q <= 1'b0;
         prev_q <= '0;
      end else if (!mon_on) begin
         have_q <= 1'b0;
      end else if (valid) begin
         have_q <= 1'b1;
         prev_q <= data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid <= 1'b0;
         fwd_data  <= '0;
      end else begin
         fwd_valid <= pass;
         if (pass) fwd_data <= data;
      end
   end

   assert_all_mode_forwards_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_on && valid && mode == COLLECT_ALL) |=> (fwd_valid && fwd_data == $past(data)));
   assert_repeat_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_on && valid && mode == COLLECT_CHANGE && have_q && data == prev_q) |=> !fwd_valid);
endmodule

// File: rtl/trc_pattern_monitor.sv
module trc_pattern_monitor
   import trc_mon_pkg::*;
#(
   parameter int          DATA_W    = 64,
   parameter int          REG_W     = 32,
   parameter int          ADDR_W    = 10,
   parameter int unsigned BASE_WORD = 'h280
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   output logic              fwd_valid,
   output logic [DATA_W-1:0] fwd_data,
   output logic              ts_req,
   output logic              trig_out
);
   localparam int NW = DATA_W / REG_W;

   if (DATA_W % REG_W != 0) begin : g_bad_split
      $error("data width must be a whole number of register words");
   end

   logic                mon_on, ts_en, accept;
   collect_mode_e       mode;
   logic [DATA_W-1:0]   ts_pat, ts_mask, tr_pat, tr_mask;

   assign accept = mon_on && smp_valid;

   trc_mon_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .NW(NW), .BASE_WORD(BASE_WORD)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .mon_on(mon_on), .mode(mode), .ts_en(ts_en),
      .ts_pat(ts_pat), .ts_mask(ts_mask), .tr_pat(tr_pat), .tr_mask(tr_mask));

   trc_mon_match #(.DW(DATA_W)) u_ts_match (
      .clk(clk), .rst_n(rst_n), .accept(accept), .gate(ts_en), .data(smp_data),
      .pat(ts_pat), .mask(ts_mask), .hit_q(ts_req));

   trc_mon_match #(.DW(DATA_W)) u_tr_match (
      .clk(clk), .rst_n(rst_n), .accept(accept), .gate(1'b1), .data(smp_data),
      .pat(tr_pat), .mask(tr_mask), .hit_q(trig_out));

   trc_mon_collect #(.DW(DATA_W)) u_collect (
      .clk(clk), .rst_n(rst_n), .mon_on(mon_on), .mode(mode), .valid(smp_valid),
      .data(smp_data), .fwd_valid(fwd_valid), .fwd_data(fwd_data));

   assert_ts_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ts_req |-> $past(ts_en && smp_valid));
   assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mon_on) |-> (!ts_req && !trig_out && !fwd_valid));
endmodule

// File: tb/trc_pattern_monitor_bench.sv
module trc_pattern_monitor_bench;
   localparam int BASE = 'h280;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr, reg_rd;
   logic [9:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        smp_valid;
   logic [63:0] smp_data, fwd_data;
   logic        fwd_valid, ts_req, trig_out;

   always #10 clk = ~clk;

   trc_pattern_monitor u_trc_pattern_monitor (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid), .smp_data(smp_data),
      .fwd_valid(fwd_valid), .fwd_data(fwd_data), .ts_req(ts_req), .trig_out(trig_out));

   int    total = 0;
   int    bad = 0;
   string cur_req = "R1";

   // reference state
   logic [31:0] mreg [10];
   bit          m_have;
   logic [63:0] m_prev;
   bit          e_fwd, e_ts, e_trig;
   logic [63:0] e_fwd_data;
   logic [31:0] e_rdata;

   task automatic check1(string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic model(bit wr, bit rd, int addr, logic [31:0] wd, bit v, logic [63:0] d);
      bit          on, chg, tsen, acc;
      logic [63:0] tsp, tsm, trp, trm;
      int          off;
      on   = mreg[0][0];
      chg  = mreg[0][1];
      tsen = mreg[1][0];
      tsp  = {mreg[3], mreg[2]};
      tsm  = {mreg[5], mreg[4]};
      trp  = {mreg[7], mreg[6]};
      trm  = {mreg[9], mreg[8]};
      acc  = v && on;
      e_trig = acc && (((d ^ trp) & trm) == 64'd0);
      e_ts   = acc && tsen && (((d ^ tsp) & tsm) == 64'd0);
      e_fwd  = acc && (!chg || !m_have || d != m_prev);
      if (e_fwd) e_fwd_data = d;
      if (!on) m_have = 0;
      else if (v) begin m_have = 1; m_prev = d; end
      off = addr - BASE;
      if (rd) e_rdata = (off >= 0 && off < 10) ? mreg[off] : 32'd0;
      if (wr && off >= 0 && off < 10)
         mreg[off] = (off == 0) ? (wd & 32'h3) : (off == 1) ? (wd & 32'h1) : wd;
   endtask

   task automatic cyc(bit wr, bit rd, int addr, logic [31:0] wd, bit v, logic [63:0] d);
      reg_wr = wr; reg_rd = rd; reg_addr = 10'(addr); reg_wdata = wd;
      smp_valid = v; smp_data = d;
      model(wr, rd, addr, wd, v, d);
      @(posedge clk);
      @(negedge clk);
      check1("fwd_valid", 64'(fwd_valid), 64'(e_fwd));
      check1("ts_req", 64'(ts_req), 64'(e_ts));
      check1("trig_out", 64'(trig_out), 64'(e_trig));
      check1("reg_rdata", 64'(reg_rdata), 64'(e_rdata));
      if (e_fwd) check1("fwd_data", fwd_data, e_fwd_data);
   endtask

   task automatic wr_reg(int a, logic [31:0] v); cyc(1, 0, a, v, 0, 64'd0); endtask
   task automatic rd_reg(int a);                 cyc(0, 1, a, 32'd0, 0, 64'd0); endtask
   task automatic smp(logic [63:0] d);           cyc(0, 0, 0, 32'd0, 1, d); endtask

   localparam logic [63:0] VA = 64'h0000_00AB_0000_00CD;
   localparam logic [63:0] VSW = 64'h0000_00CD_0000_00AB;
   localparam logic [63:0] VB = 64'h1234_5678_9ABC_DEF0;

   initial begin
      logic [63:0] pool [4];
      pool[0] = VA; pool[1] = VB; pool[2] = VSW; pool[3] = 64'd0;
      for (int i = 0; i < 10; i++) mreg[i] = 32'd0;
      m_have = 0; m_prev = 64'd0; e_fwd = 0; e_ts = 0; e_trig = 0;
      e_fwd_data = 64'd0; e_rdata = 32'd0;
      rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
      smp_valid = 0; smp_data = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values
      cur_req = "R1";
      check1("fwd_valid", 64'(fwd_valid), 64'd0);
      check1("ts_req", 64'(ts_req), 64'd0);
      check1("trig_out", 64'(trig_out), 64'd0);
      check1("reg_rdata", 64'(reg_rdata), 64'd0);
      for (int a = BASE; a < BASE + 10; a++) rd_reg(a);
      // R2: control bits and read timing
      cur_req = "R2";
      wr_reg(BASE, 32'hFFFF_FFFC);
      rd_reg(BASE);
      wr_reg(BASE + 1, 32'hFFFF_FFFF);
      rd_reg(BASE + 1);
      cyc(0, 0, BASE, 32'd0, 0, 64'd0);   // rdata must hold
      wr_reg(BASE + 1, 32'd0);
      // R3: unmapped window
      cur_req = "R3";
      wr_reg(BASE + 10, 32'hDEAD_BEEF);
      rd_reg(BASE + 10);
      rd_reg(BASE - 1);
      rd_reg(0);
      wr_reg(BASE - 1, 32'h3);
      rd_reg(BASE);
      // R7: patterns set but monitor off
      cur_req = "R7";
      wr_reg(BASE + 6, 32'hCD); wr_reg(BASE + 7, 32'hAB);
      wr_reg(BASE + 8, 32'hFFFF_FFFF); wr_reg(BASE + 9, 32'hFFFF_FFFF);
      wr_reg(BASE + 1, 32'h1);
      smp(VA); smp(VB); smp(VA);
      // R5, R8, R10: monitor on, all-samples mode
      cur_req = "R5";
      wr_reg(BASE, 32'h1);
      smp(VA); smp(VA);
      cur_req = "R10";
      smp(VSW); rd_reg(BASE + 6); rd_reg(BASE + 7);
      cur_req = "R8";
      smp(VB); cyc(0, 0, 0, 0, 0, VA); smp(VB);
      // R6: timestamp gate with zero mask (R4) matches all
      cur_req = "R6";
      wr_reg(BASE + 1, 32'h0);
      smp(VB); smp(VA);
      wr_reg(BASE + 1, 32'h1);
      cur_req = "R4";
      smp(VB); smp(VSW);
      wr_reg(BASE + 4, 32'h0000_00FF); wr_reg(BASE + 2, 32'h0000_00F0);
      smp(VB); smp(VA); smp(64'h0000_0000_0000_00F0);
      wr_reg(BASE + 8, 32'h0);
      smp(VSW); smp(VB);
      // R9: change-only mode
      cur_req = "R9";
      wr_reg(BASE, 32'h3);
      smp(VA); smp(VA); smp(VA); smp(VB); smp(VA); smp(VA);
      cyc(0, 0, 0, 0, 0, VB); smp(VA);
      wr_reg(BASE, 32'h2);
      smp(VB);
      wr_reg(BASE, 32'h3);
      smp(VA); smp(VA);
      // mixed random stretch
      cur_req = "R5";
      for (int i = 0; i < 600; i++) begin
         int k;
         k = int'($urandom % 10);
         if (k == 0)
            cyc(1, 0, BASE + int'($urandom % 10), (($urandom % 3) == 0) ? $urandom : 32'h3,
                $urandom % 2, pool[$urandom % 4]);
         else if (k == 1)
            cyc(0, 1, BASE - 1 + int'($urandom % 12), 32'd0, $urandom % 2, pool[$urandom % 4]);
         else
            cyc(0, 0, 0, 32'd0, $urandom % 2, pool[$urandom % 4]);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL %s watchdog: actual=timeout expected=completion", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule